// File: doc/BRIEF.md
# Byte Cache with Selectable Write Policy

This block is a small two-way set-associative data cache that sits between a byte-wide processor port and a backing memory. A single parameter chooses how stores are handled. With write-back selected, a store changes only the cached copy and marks that line dirty. The whole line goes back to memory only when the line is replaced. With write-through selected, no dirty state exists at all. Every store updates the cache if the line is present, and it always sends just the one modified byte to memory at once.

Each address splits into three fields. The low bits are the byte offset inside a block, the next bits are the set index, and the remaining upper bits are the tag. With the defaults (8-bit addresses, 16-byte blocks, two sets) the split is offset = bits [3:0], index = bit [4] and tag = bits [7:5]. Each set holds two lines. The victim is the least recently used line, except that an empty way is always taken first.

A request is offered with `cpu_valid` and accepted on a clock edge where `cpu_ready` is high. A hit answers on `resp_valid` in the very next cycle. A miss, or a write-through store, lowers `cpu_ready` until the memory transfers end, and then answers. The controller has four states:
- `ST_IDLE`: accepts requests and serves hits.
- `ST_EVICT`: writes a dirty victim block to memory.
- `ST_FILL`: reads the missing block from memory.
- `ST_WTBYTE`: sends a single byte to memory.

The transitions are:
- IDLE→EVICT on a miss whose victim is dirty.
- IDLE→FILL on a miss whose victim is clean or empty.
- IDLE→WTBYTE on any write-through store.
- EVICT→FILL on acknowledge.
- FILL→IDLE and WTBYTE→IDLE on acknowledge.

Top module: `bytecache`

## Requirements
- R1: Address fields are offset = addr[3:0], index = addr[4], tag = addr[7:5]. Bytes in one 16-byte block share a line. Two blocks whose addresses differ by a multiple of 32 fall in the same set, and both can be resident at once in its two ways.
- R2: A read hit is answered with `resp_valid` high in the cycle right after acceptance, with the cached byte, and with no memory request.
- R3: A read miss holds `cpu_ready` low. It issues a block read (mem_op = 0) at the block-aligned address, installs the block, and then answers with the byte from memory.
- R4: On a miss, an empty way is filled first. Otherwise the least recently used way of the set is replaced. Both hits and fills count as uses.
- R5: In write-back mode a store hit is answered one cycle after acceptance. It changes the cached byte and marks the line dirty. It never changes memory and never issues a byte write (mem_op = 2).
- R6: In write-back mode, a miss that replaces a dirty line first writes the whole 16-byte victim block (mem_op = 1) to the victim's own block address. That write completes before the fill read is issued.
- R7: In write-back mode, replacing a clean line issues no block write.
- R8: In write-back mode a store miss fetches the block, merges the stored byte into it, and marks the line dirty. A later read of that address hits and returns the stored byte.
- R9: In write-through mode every store issues exactly one byte write (mem_op = 2) of the stored byte to its address, and no block write is ever issued. The store is answered once memory acknowledges it, and a resident line is updated as well.
- R10: In write-through mode a store miss does not allocate. It issues no block read, and a later read of that address misses.
- R11: `mem_req`, `mem_op` and `mem_addr` stay steady from the rise of `mem_req` until `mem_ack`.
- R12: After reset all lines are empty, `cpu_ready` is high, and `mem_req` and `resp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Request offered |
| cpu_ready | output | 1 | Request can be accepted this cycle |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Store data |
| resp_valid | output | 1 | One-cycle pulse that completes a request |
| resp_data | output | 8 | Loaded byte, or the stored byte for a store |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_op | output | 2 | 0 block read, 1 block write, 2 byte write |
| mem_addr | output | ADDR_W | Block-aligned address for block operations, byte address for a byte write |
| mem_wblock | output | 8*BLOCK_BYTES | Block data for a block write |
| mem_wbyte | output | 8 | Byte data for a byte write |
| mem_ack | input | 1 | One-cycle completion of the memory request |
| mem_rblock | input | 8*BLOCK_BYTES | Block data, valid with `mem_ack` on a block read |

## Verification
A load hit and a write-back store hit are due exactly one cycle after the accepting edge. The bench samples on the first falling edge after that edge and requires `resp_valid` there. Misses and write-through stores finish a known number of memory handshakes later. For these the bench waits at falling edges for the pulse, requires that it comes later than one cycle, and compares counts of each memory operation kind against a reference model of tags, dirty bits and LRU. After each pulse it inspects the backing memory, and it compares the times of the victim write and the fill read.

// File: rtl/bc_pkg.sv
package bc_pkg;

    typedef enum logic [1:0] {
        MOP_RD_BLK  = 2'd0,
        MOP_WR_BLK  = 2'd1,
        MOP_WR_BYTE = 2'd2
    } mem_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_WTBYTE
    } ctl_state_e;

endpackage

// File: rtl/bc_tagdir.sv
module bc_tagdir #(
    parameter bit WRITE_BACK = 1'b1,
    parameter int NUM_SETS   = 2,
    parameter int IDX_W      = 1,
    parameter int TAG_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic             lk_way,
    output logic             vic_way,
    output logic             vic_dirty,
    output logic [TAG_W-1:0] vic_tag,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_way,
    input  logic             upd_install,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic             upd_dirty
);

    logic             vld [NUM_SETS][2];
    logic             drt [NUM_SETS][2];
    logic [TAG_W-1:0] tg  [NUM_SETS][2];
    logic             lru [NUM_SETS];   // way to replace next

    logic hit0, hit1;

    always_comb begin
        hit0      = vld[lk_idx][0] && (tg[lk_idx][0] == lk_tag);
        hit1      = vld[lk_idx][1] && (tg[lk_idx][1] == lk_tag);
        lk_hit    = hit0 | hit1;
        lk_way    = hit1;
        if (!vld[lk_idx][0])      vic_way = 1'b0;
        else if (!vld[lk_idx][1]) vic_way = 1'b1;
        else                      vic_way = lru[lk_idx];
        vic_dirty = vld[lk_idx][vic_way] && drt[lk_idx][vic_way];
        vic_tag   = tg[lk_idx][vic_way];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                lru[s] <= 1'b0;
                for (int w = 0; w < 2; w++) begin
                    vld[s][w] <= 1'b0;
                    drt[s][w] <= 1'b0;
                    tg[s][w]  <= '0;
                end
            end
        end else if (upd_en) begin
            lru[upd_idx] <= ~upd_way;
            if (upd_install) begin
                vld[upd_idx][upd_way] <= 1'b1;
                tg[upd_idx][upd_way]  <= upd_tag;
                drt[upd_idx][upd_way] <= WRITE_BACK && upd_dirty;
            end else if (WRITE_BACK && upd_dirty) begin
                drt[upd_idx][upd_way] <= 1'b1;
            end
        end
    end

    // R1: a set never holds the same block in both ways
    for (genvar s = 0; s < NUM_SETS; s++) begin : g_uniq
        a_r1_unique_tags: assert property (@(posedge clk) disable iff (!rst_n)
            (vld[s][0] && vld[s][1]) |-> (tg[s][0] != tg[s][1]));
    end

endmodule

// File: rtl/bc_data.sv
module bc_data #(
    parameter int NUM_SETS    = 2,
    parameter int IDX_W       = 1,
    parameter int BLOCK_BYTES = 16,
    parameter int OFF_W       = 4
) (
    input  logic                     clk,
    input  logic [IDX_W-1:0]         rd_idx,
    input  logic                     rd_way,
    output logic [BLOCK_BYTES*8-1:0] rd_block,
    input  logic                     wr_en,
    input  logic                     wr_full,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic                     wr_way,
    input  logic [OFF_W-1:0]         wr_off,
    input  logic [7:0]               wr_byte,
    input  logic [BLOCK_BYTES*8-1:0] wr_block
);

    logic [BLOCK_BYTES*8-1:0] blk [NUM_SETS][2];

    assign rd_block = blk[rd_idx][rd_way];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_full) blk[wr_idx][wr_way] <= wr_block;
            else         blk[wr_idx][wr_way][{wr_off, 3'b000} +: 8] <= wr_byte;
        end
    end

endmodule

// File: rtl/bytecache.sv
module bytecache
    import bc_pkg::*;
#(
    parameter bit WRITE_BACK  = 1'b1,
    parameter int ADDR_W      = 8,
    parameter int BLOCK_BYTES = 16,
    parameter int NUM_SETS    = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_valid,
    output logic                     cpu_ready,
    input  logic                     cpu_we,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [7:0]               cpu_wdata,
    output logic                     resp_valid,
    output logic [7:0]               resp_data,
    output logic                     mem_req,
    output logic [1:0]               mem_op,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [BLOCK_BYTES*8-1:0] mem_wblock,
    output logic [7:0]               mem_wbyte,
    input  logic                     mem_ack,
    input  logic [BLOCK_BYTES*8-1:0] mem_rblock
);

    localparam int OFF_W = $clog2(BLOCK_BYTES);
    localparam int IDX_W = $clog2(NUM_SETS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int BLK_W = BLOCK_BYTES * 8;

    ctl_state_e st, nxt;

    logic              req_we;
    logic [ADDR_W-1:0] req_addr;
    logic [7:0]        req_wdata;
    logic              vic_way_q;
    logic [TAG_W-1:0]  vic_tag_q;

    logic [OFF_W-1:0]  c_off, q_off;
    logic [IDX_W-1:0]  c_idx, q_idx, lk_idx;
    logic [TAG_W-1:0]  c_tag, q_tag, lk_tag;

    assign c_off = cpu_addr[OFF_W-1:0];
    assign c_idx = cpu_addr[OFF_W +: IDX_W];
    assign c_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign q_off = req_addr[OFF_W-1:0];
    assign q_idx = req_addr[OFF_W +: IDX_W];
    assign q_tag = req_addr[ADDR_W-1 -: TAG_W];

    assign lk_idx = (st == ST_IDLE) ? c_idx : q_idx;
    assign lk_tag = (st == ST_IDLE) ? c_tag : q_tag;

    logic             lk_hit, lk_way, vic_way, vic_dirty;
    logic [TAG_W-1:0] vic_tag;
    logic             upd_en, upd_way, upd_install, upd_dirty;
    logic [IDX_W-1:0] upd_idx;
    logic [TAG_W-1:0] upd_tag;

    bc_tagdir #(
        .WRITE_BACK (WRITE_BACK),
        .NUM_SETS   (NUM_SETS),
        .IDX_W      (IDX_W),
        .TAG_W      (TAG_W)
    ) u_tagdir (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_idx      (lk_idx),
        .lk_tag      (lk_tag),
        .lk_hit      (lk_hit),
        .lk_way      (lk_way),
        .vic_way     (vic_way),
        .vic_dirty   (vic_dirty),
        .vic_tag     (vic_tag),
        .upd_en      (upd_en),
        .upd_idx     (upd_idx),
        .upd_way     (upd_way),
        .upd_install (upd_install),
        .upd_tag     (upd_tag),
        .upd_dirty   (upd_dirty)
    );

    logic             rd_way;
    logic [BLK_W-1:0] rd_block, fill_merged, dw_block;
    logic             dw_en, dw_full, dw_way;
    logic [IDX_W-1:0] dw_idx;
    logic [OFF_W-1:0] dw_off;
    logic [7:0]       dw_byte, rd_byte;

    assign rd_way  = (st == ST_IDLE) ? lk_way : vic_way_q;
    assign rd_byte = rd_block[{c_off, 3'b000} +: 8];

    bc_data #(
        .NUM_SETS    (NUM_SETS),
        .IDX_W       (IDX_W),
        .BLOCK_BYTES (BLOCK_BYTES),
        .OFF_W       (OFF_W)
    ) u_data (
        .clk      (clk),
        .rd_idx   (lk_idx),
        .rd_way   (rd_way),
        .rd_block (rd_block),
        .wr_en    (dw_en),
        .wr_full  (dw_full),
        .wr_idx   (dw_idx),
        .wr_way   (dw_way),
        .wr_off   (dw_off),
        .wr_byte  (dw_byte),
        .wr_block (dw_block)
    );

    logic accept;
    assign cpu_ready = (st == ST_IDLE);
    assign accept    = cpu_valid && cpu_ready;

    always_comb begin
        fill_merged = mem_rblock;
        if (req_we) fill_merged[{q_off, 3'b000} +: 8] = req_wdata;
    end

    // next state and datapath controls
    always_comb begin
        nxt         = st;
        upd_en      = 1'b0;
        upd_idx     = c_idx;
        upd_way     = lk_way;
        upd_install = 1'b0;
        upd_tag     = c_tag;
        upd_dirty   = 1'b0;
        dw_en       = 1'b0;
        dw_full     = 1'b0;
        dw_idx      = c_idx;
        dw_way      = lk_way;
        dw_off      = c_off;
        dw_byte     = cpu_wdata;
        dw_block    = fill_merged;
        unique case (st)
            ST_IDLE: begin
                if (accept) begin
                    if (lk_hit) begin
                        upd_en = 1'b1;
                        if (cpu_we) begin
                            dw_en     = 1'b1;
                            upd_dirty = WRITE_BACK;
                            if (!WRITE_BACK) nxt = ST_WTBYTE;
                        end
                    end else if (cpu_we && !WRITE_BACK) begin
                        nxt = ST_WTBYTE;
                    end else if (vic_dirty) begin
                        nxt = ST_EVICT;
                    end else begin
                        nxt = ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                if (mem_ack) nxt = ST_FILL;
            end
            ST_FILL: begin
                if (mem_ack) begin
                    dw_en       = 1'b1;
                    dw_full     = 1'b1;
                    dw_idx      = q_idx;
                    dw_way      = vic_way_q;
                    upd_en      = 1'b1;
                    upd_idx     = q_idx;
                    upd_way     = vic_way_q;
                    upd_install = 1'b1;
                    upd_tag     = q_tag;
                    upd_dirty   = req_we;
                    nxt         = ST_IDLE;
                end
            end
            ST_WTBYTE: begin
                if (mem_ack) nxt = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // registered outputs and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_data  <= '0;
            req_we     <= 1'b0;
            req_addr   <= '0;
            req_wdata  <= '0;
            vic_way_q  <= 1'b0;
            vic_tag_q  <= '0;
        end else begin
            resp_valid <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (accept) begin
                        req_we    <= cpu_we;
                        req_addr  <= cpu_addr;
                        req_wdata <= cpu_wdata;
                        vic_way_q <= vic_way;
                        vic_tag_q <= vic_tag;
                        if (lk_hit && !(cpu_we && !WRITE_BACK)) begin
                            resp_valid <= 1'b1;
                            resp_data  <= cpu_we ? cpu_wdata : rd_byte;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        resp_valid <= 1'b1;
                        resp_data  <= req_we ? req_wdata : mem_rblock[{q_off, 3'b000} +: 8];
                    end
                end
                ST_WTBYTE: begin
                    if (mem_ack) begin
                        resp_valid <= 1'b1;
                        resp_data  <= req_wdata;
                    end
                end
                ST_EVICT: ;
            endcase
        end
    end

    // memory port
    always_comb begin
        mem_req    = (st != ST_IDLE);
        mem_op     = MOP_RD_BLK;
        mem_addr   = {q_tag, q_idx, {OFF_W{1'b0}}};
        mem_wblock = rd_block;
        mem_wbyte  = req_wdata;
        unique case (st)
            ST_EVICT:  begin
                mem_op   = MOP_WR_BLK;
                mem_addr = {vic_tag_q, q_idx, {OFF_W{1'b0}}};
            end
            ST_WTBYTE: begin
                mem_op   = MOP_WR_BYTE;
                mem_addr = req_addr;
            end
            ST_FILL, ST_IDLE: ;
        endcase
    end

    // R11: request fields hold until acknowledged
    a_r11_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_op)));

    // R6: a finished victim write is followed by the fill read
    a_r6_evict_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_op == MOP_WR_BLK) |=> (mem_req && mem_op == MOP_RD_BLK));

    // R2: a load hit answers on the next cycle
    a_r2_hit_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lk_hit && !cpu_we) |=> resp_valid);

    // R3: a miss stalls the port
    a_r3_miss_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !lk_hit) |=> !cpu_ready);

    if (WRITE_BACK) begin : g_wb_chk
        // R5: write-back never sends single bytes
        a_r5_no_byte_write: assert property (@(posedge clk) disable iff (!rst_n)
            !(mem_req && mem_op == MOP_WR_BYTE));
    end else begin : g_wt_chk
        // R9: write-through never writes whole blocks
        a_r9_no_block_write: assert property (@(posedge clk) disable iff (!rst_n)
            !(mem_req && mem_op == MOP_WR_BLK));
    end

endmodule

// File: tb/bytecache_tb.sv
`timescale 1ns/1ps
module bytecache_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic         cv [2];
    logic         cw [2];
    logic [7:0]   ca [2];
    logic [7:0]   cd [2];
    logic         cr [2];
    logic         rv [2];
    logic [7:0]   rd [2];
    logic         mreq [2];
    logic [1:0]   mop [2];
    logic [7:0]   maddr [2];
    logic [127:0] mwblk [2];
    logic [7:0]   mwbyte [2];
    logic         mack [2];
    logic [127:0] mrblk [2];

    bytecache #(.WRITE_BACK(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cv[0]), .cpu_ready(cr[0]), .cpu_we(cw[0]), .cpu_addr(ca[0]), .cpu_wdata(cd[0]),
        .resp_valid(rv[0]), .resp_data(rd[0]),
        .mem_req(mreq[0]), .mem_op(mop[0]), .mem_addr(maddr[0]), .mem_wblock(mwblk[0]),
        .mem_wbyte(mwbyte[0]), .mem_ack(mack[0]), .mem_rblock(mrblk[0]));

    bytecache #(.WRITE_BACK(1'b0)) u_dut_wt (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cv[1]), .cpu_ready(cr[1]), .cpu_we(cw[1]), .cpu_addr(ca[1]), .cpu_wdata(cd[1]),
        .resp_valid(rv[1]), .resp_data(rd[1]),
        .mem_req(mreq[1]), .mem_op(mop[1]), .mem_addr(maddr[1]), .mem_wblock(mwblk[1]),
        .mem_wbyte(mwbyte[1]), .mem_ack(mack[1]), .mem_rblock(mrblk[1]));

    function automatic logic [7:0] init_byte(int k, int i);
        return 8'((i * 37 + 11 + k * 5) & 255);
    endfunction

    // backing memory models, acknowledge after three request cycles
    logic [7:0] bm [2][256];
    int dly [2], n_rd [2], n_wr [2], n_byte [2], drop_bad [2];
    bit pend [2];
    time t_rd [2], t_wr [2];

    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                mack[k] <= 1'b0; dly[k] <= 0; pend[k] <= 1'b0;
                n_rd[k] <= 0; n_wr[k] <= 0; n_byte[k] <= 0; drop_bad[k] <= 0;
                mrblk[k] <= '0; t_rd[k] <= 0; t_wr[k] <= 0;
                for (int i = 0; i < 256; i++) bm[k][i] <= init_byte(k, i);
            end else begin
                pend[k] <= mreq[k] && !mack[k];
                if (pend[k] && !mreq[k]) drop_bad[k] <= drop_bad[k] + 1;
                if (mack[k]) begin
                    mack[k] <= 1'b0;
                end else if (mreq[k]) begin
                    if (dly[k] == 2) begin
                        dly[k]  <= 0;
                        mack[k] <= 1'b1;
                        case (mop[k])
                            2'd0: begin
                                for (int b = 0; b < 16; b++)
                                    mrblk[k][8*b +: 8] <= bm[k][{maddr[k][7:4], 4'h0} + b];
                                n_rd[k] <= n_rd[k] + 1; t_rd[k] <= $time;
                            end
                            2'd1: begin
                                for (int b = 0; b < 16; b++)
                                    bm[k][{maddr[k][7:4], 4'h0} + b] <= mwblk[k][8*b +: 8];
                                n_wr[k] <= n_wr[k] + 1; t_wr[k] <= $time;
                            end
                            default: begin
                                bm[k][maddr[k]] <= mwbyte[k];
                                n_byte[k] <= n_byte[k] + 1;
                            end
                        endcase
                    end else begin
                        dly[k] <= dly[k] + 1;
                    end
                end
            end
        end
    end

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // reference model
    bit         mv [2][2][2];
    bit         md [2][2][2];
    logic [2:0] mt [2][2][2];
    bit         ml [2][2];
    logic [7:0] arch [2][256];

    task automatic txn(input int k, input bit we, input logic [7:0] a, input logic [7:0] d,
                       output int lat, output int wrb);
        bit wb = (k == 0);
        int ix = int'(a[4]);
        logic [2:0] tg = a[7:5];
        bit hit = 1'b0;
        int hw = 0, vw = 0;
        bit ev = 1'b0;
        int e_rd = 0, e_wr = 0, e_by = 0;
        int s_rd, s_wr, s_by;
        logic [7:0] old_m, exp_d, ev_base;
        string tr, tl;
        for (int w = 0; w < 2; w++)
            if (mv[k][ix][w] && mt[k][ix][w] == tg) begin hit = 1'b1; hw = w; end
        if (!hit) begin
            vw = !mv[k][ix][0] ? 0 : (!mv[k][ix][1] ? 1 : int'(ml[k][ix]));
            ev = mv[k][ix][vw] && md[k][ix][vw];
        end
        ev_base = {mt[k][ix][vw], a[4], 4'h0};
        if (we && !wb) e_by = 1;
        else if (!hit) begin e_rd = 1; e_wr = ev ? 1 : 0; end
        exp_d = we ? d : arch[k][a];
        old_m = bm[k][a];
        s_rd = n_rd[k]; s_wr = n_wr[k]; s_by = n_byte[k];

        @(negedge clk);
        cv[k] = 1'b1; cw[k] = we; ca[k] = a; cd[k] = d;
        @(posedge clk);
        lat = 0;
        do begin
            @(negedge clk);
            cv[k] = 1'b0;
            lat++;
        end while (!rv[k] && lat < 200);

        tr = we ? (wb ? "R5" : "R9") : (hit ? "R2" : "R3");
        chk(rv[k] && rd[k] == exp_d, tr, rd[k], exp_d);
        if (hit && !(we && !wb)) chk(lat == 1, hit && !we ? "R2 hit latency" : "R5 hit latency", lat, 1);
        else chk(lat > 1, we && !wb ? "R9 byte write waits" : "R3 miss stalls", lat, 2);
        tl = wb ? (ev ? "R6" : "R7") : "R9";
        chk(n_wr[k] - s_wr == e_wr, tl, n_wr[k] - s_wr, e_wr);
        chk(n_rd[k] - s_rd == e_rd, wb ? "R3 fill count" : "R10 fill count", n_rd[k] - s_rd, e_rd);
        chk(n_byte[k] - s_by == e_by, wb ? "R5 byte count" : "R9 byte count", n_byte[k] - s_by, e_by);
        wrb = n_wr[k] - s_wr;
        if (ev) begin
            chk(t_wr[k] < t_rd[k], "R6 order", int'(t_wr[k]), int'(t_rd[k]));
            for (int b = 0; b < 16; b++)
                chk(bm[k][ev_base + b] == arch[k][ev_base + b], "R6 block data",
                    bm[k][ev_base + b], arch[k][ev_base + b]);
        end
        if (we && !wb) chk(bm[k][a] == d, "R9 memory byte", bm[k][a], d);
        if (we && wb)  chk(bm[k][a] == old_m, "R5 memory kept", bm[k][a], old_m);

        // advance the model
        if (hit) begin
            ml[k][ix] = ~1'(hw);
            if (we && wb) md[k][ix][hw] = 1'b1;
        end else if (!(we && !wb)) begin
            mv[k][ix][vw] = 1'b1;
            mt[k][ix][vw] = tg;
            md[k][ix][vw] = we && wb;
            ml[k][ix] = ~1'(vw);
        end
        if (we) arch[k][a] = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int lat, wrb;
        void'($urandom(1234));
        for (int k = 0; k < 2; k++) begin
            cv[k] = 1'b0; cw[k] = 1'b0; ca[k] = '0; cd[k] = '0;
            ml[k][0] = 1'b0; ml[k][1] = 1'b0;
            for (int s = 0; s < 2; s++)
                for (int w = 0; w < 2; w++) begin
                    mv[k][s][w] = 1'b0; md[k][s][w] = 1'b0; mt[k][s][w] = '0;
                end
            for (int i = 0; i < 256; i++) arch[k][i] = init_byte(k, i);
        end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk(cr[k] == 1'b1, "R12 ready", cr[k], 1);
            chk(mreq[k] == 1'b0, "R12 no request", mreq[k], 0);
            chk(rv[k] == 1'b0, "R12 no response", rv[k], 0);
        end

        // write-back directed
        txn(0, 0, 8'h03, 0, lat, wrb); chk(lat > 1, "R12 empty after reset", lat, 2);
        txn(0, 0, 8'h0E, 0, lat, wrb); chk(lat == 1, "R1 same block hits", lat, 1);
        txn(0, 0, 8'h23, 0, lat, wrb); chk(wrb == 0, "R4 empty way used", wrb, 0);
        txn(0, 0, 8'h03, 0, lat, wrb); chk(lat == 1, "R1 two blocks share set", lat, 1);
        txn(0, 1, 8'h07, 8'hA5, lat, wrb);
        txn(0, 0, 8'h43, 0, lat, wrb); chk(wrb == 0, "R7 clean victim", wrb, 0);
        txn(0, 0, 8'h05, 0, lat, wrb); chk(lat == 1, "R4 recent way kept", lat, 1);
        txn(0, 0, 8'h23, 0, lat, wrb); chk(lat > 1, "R4 LRU way replaced", lat, 2);
        txn(0, 0, 8'h63, 0, lat, wrb); chk(wrb == 1, "R6 dirty victim written", wrb, 1);
        txn(0, 1, 8'h9A, 8'h3C, lat, wrb); chk(lat > 1, "R8 write miss fetches", lat, 2);
        txn(0, 0, 8'h9A, 0, lat, wrb); chk(lat == 1, "R8 allocated", lat, 1);

        // write-through directed
        txn(1, 0, 8'h03, 0, lat, wrb);
        txn(1, 1, 8'h05, 8'h77, lat, wrb); chk(wrb == 0, "R9 no block write", wrb, 0);
        txn(1, 0, 8'h05, 0, lat, wrb); chk(lat == 1, "R9 line updated", lat, 1);
        txn(1, 1, 8'h45, 8'h19, lat, wrb);
        txn(1, 0, 8'h45, 0, lat, wrb); chk(lat > 1, "R10 no allocate", lat, 2);

        // constrained random mix
        for (int n = 0; n < 300; n++) begin
            for (int k = 0; k < 2; k++) begin
                logic [7:0] ra = 8'($urandom_range(0, 127));
                logic [7:0] rdv = 8'($urandom_range(0, 255));
                bit rwe = 1'($urandom_range(0, 2) == 0);
                txn(k, rwe, ra, rdv, lat, wrb);
            end
        end
        for (int k = 0; k < 2; k++)
            chk(drop_bad[k] == 0, "R11 request held", drop_bad[k], 0);
        finish_run();
    end

endmodule